// File: doc/BRIEF.md
# Reorder Buffer with Branch Rollback

This block tracks in-flight instructions between rename and retirement in an out-of-order core. The front end writes one instruction per cycle into a 16-slot circular buffer in program order. Each slot records:

- whether it is occupied and finished;
- whether its result raised a fault;
- whether it is a branch;
- its architectural destination, the physical register it was given, and the physical register that held the same architectural name before it.

Execution units report finished work in any order by naming the slot index. The oldest slot retires once it is finished. On retirement, the older physical register goes back to the free list.

A branch that resolves wrong can do so while older and younger branches are still pending. When that happens, the buffer drops every slot younger than that branch and moves its allocation point back to the slot just after it. The same cycle it raises a kill toward the execution pipelines, together with the corrected fetch address.

A fault is stored when the work finishes, but the buffer acts on it only when that slot becomes the oldest. At that point the whole buffer is emptied and fetch is sent to a fixed handler address.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready_o` is 1, `disp_idx_o` is 0, and `cmt_valid_o` and `kill_valid_o` are 0.
- R2: When `disp_valid_i` and `disp_ready_o` are both high, the instruction goes into slot `disp_idx_o`, and the next slot index is one higher, modulo 16. With 16 slots held, `disp_ready_o` is 0 and a dispatch request changes nothing.
- R3: A completion with `cmpl_valid_i` marks the slot named by `cmpl_idx_i` as finished. Slots may finish in any order.
- R4: `cmt_valid_o` is high in exactly the cycles in which the oldest slot is occupied, finished and not faulted. In those cycles the block outputs that slot's architectural destination, its new physical register, and its previous physical register (the one to release). At most one slot retires per cycle, always in dispatch order.
- R5: A completion naming a slot that is not occupied (never dispatched, already retired, or killed) has no effect.
- R6: A completion with `cmpl_mispredict_i` on an occupied branch slot drives, in the same cycle, `kill_valid_o`=1, `kill_all_o`=0, `kill_branch_idx_o` equal to that slot, and `redirect_pc_o` equal to `cmpl_target_i`. Every younger slot is dropped, and the next dispatch index becomes the branch slot plus one.
- R7: A mispredict flag on a completion for a slot that was not dispatched as a branch is treated as a plain completion: nothing is killed.
- R8: A fault flag given with a completion is stored. When the faulting slot is oldest and finished, the block drives `kill_valid_o`=1, `kill_all_o`=1 and `redirect_pc_o`=`HANDLER_PC`, retires nothing, and empties the buffer, so the next dispatch index is 0.
- R9: A dispatch request in a cycle that kills anything is dropped. A completion in a cycle that flushes on a fault is ignored.
- R10: A fault flush at the oldest slot takes priority over a mispredict reported in the same cycle.
- R11: Several branches may be pending at once and may resolve in any order. A branch completion without the mispredict flag kills nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_branch_i | input | 1 | Dispatched instruction is a branch |
| disp_areg_i | input | 5 | Architectural destination |
| disp_pnew_i | input | 7 | Newly assigned physical destination |
| disp_pold_i | input | 7 | Previous physical mapping of that destination |
| disp_ready_o | output | 1 | Buffer has a free slot |
| disp_idx_o | output | 4 | Slot the next dispatch will use |
| cmpl_valid_i | input | 1 | Completion report |
| cmpl_idx_i | input | 4 | Slot that finished |
| cmpl_exc_i | input | 1 | Finished work raised a fault |
| cmpl_mispredict_i | input | 1 | Branch resolved against its prediction |
| cmpl_target_i | input | PC_W | Correct fetch address for a mispredict |
| cmt_valid_o | output | 1 | Oldest slot retires this cycle |
| cmt_areg_o | output | 5 | Retiring architectural destination |
| cmt_pnew_o | output | 7 | Retiring physical destination |
| cmt_free_preg_o | output | 7 | Physical register returned to the free list |
| kill_valid_o | output | 1 | Kill in-flight work this cycle |
| kill_all_o | output | 1 | Kill is a full flush for a fault |
| kill_branch_idx_o | output | 4 | Mispredicted branch slot; younger work dies |
| redirect_pc_o | output | PC_W | New fetch address while a kill is signalled |

## Verification
The embedded properties check, on every cycle, these step relations:

- a stalled allocation pointer holds still when the buffer is full and nothing is killed;
- the allocation point lands one past the branch after a rollback;
- a fault flush leaves an empty buffer;
- the oldest slot advances by exactly one per retirement;
- the occupancy never passes the depth.

Only the bench's scenarios can show the behaviours that depend on history:

- the order in which released registers appear;
- that a report to a killed slot changes nothing;
- that a fault waits for older slots to finish;
- how a fault and a mispredict interact, when they occur in the same cycle or in different cycles.

The bench's model mirrors the buffer's contents as an ordered list and compares every output on every cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int unsigned ROB_DEPTH = 16;
    localparam int unsigned IDX_W     = $clog2(ROB_DEPTH);
    localparam int unsigned CNT_W     = IDX_W + 1;
    localparam int unsigned AREG_W    = 5;
    localparam int unsigned PREG_W    = 7;

    typedef logic [IDX_W-1:0] rob_idx_t;
    typedef logic [CNT_W-1:0] rob_cnt_t;

    typedef struct packed {
        logic              used;
        logic              done;
        logic              exc;
        logic              branch;
        logic [AREG_W-1:0] areg;
        logic [PREG_W-1:0] pnew;
        logic [PREG_W-1:0] pold;
    } rob_entry_t;

    typedef struct packed {
        rob_entry_t [ROB_DEPTH-1:0] ent;
        rob_idx_t                   head;
        rob_idx_t                   tail;
        rob_cnt_t                   cnt;
    } rob_state_t;
endpackage

// File: rtl/rob_age_kill.sv
module rob_age_kill
    import rob_pkg::*;
(
    input  rob_idx_t               head_i,
    input  rob_idx_t               brn_i,
    output rob_idx_t               brn_age_o,
    output logic [ROB_DEPTH-1:0]   younger_o
);
    // age = distance from the oldest slot, wrapping modulo the depth
    assign brn_age_o = brn_i - head_i;

    for (genvar g = 0; g < ROB_DEPTH; g++) begin : g_age
        rob_idx_t slot_age;
        assign slot_age     = rob_idx_t'(g) - head_i;
        assign younger_o[g] = (slot_age > brn_age_o);
    end
endmodule

// File: rtl/rob_head_view.sv
module rob_head_view
    import rob_pkg::*;
(
    input  rob_entry_t head_ent_i,
    output logic       retire_ok_o,
    output logic       fault_o
);
    logic finished;
    assign finished    = head_ent_i.used & head_ent_i.done;
    assign retire_ok_o = finished & ~head_ent_i.exc;
    assign fault_o     = finished &  head_ent_i.exc;
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int unsigned PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid_i,
    input  logic              disp_branch_i,
    input  logic [AREG_W-1:0] disp_areg_i,
    input  logic [PREG_W-1:0] disp_pnew_i,
    input  logic [PREG_W-1:0] disp_pold_i,
    output logic              disp_ready_o,
    output logic [IDX_W-1:0]  disp_idx_o,
    input  logic              cmpl_valid_i,
    input  logic [IDX_W-1:0]  cmpl_idx_i,
    input  logic              cmpl_exc_i,
    input  logic              cmpl_mispredict_i,
    input  logic [PC_W-1:0]   cmpl_target_i,
    output logic              cmt_valid_o,
    output logic [AREG_W-1:0] cmt_areg_o,
    output logic [PREG_W-1:0] cmt_pnew_o,
    output logic [PREG_W-1:0] cmt_free_preg_o,
    output logic              kill_valid_o,
    output logic              kill_all_o,
    output logic [IDX_W-1:0]  kill_branch_idx_o,
    output logic [PC_W-1:0]   redirect_pc_o
);
    localparam rob_cnt_t FULL_CNT = rob_cnt_t'(ROB_DEPTH);

    rob_state_t st_q, st_d;

    logic                 retire_ok, fault_flush;
    logic                 cmpl_hit, mispredict, disp_fire, not_full;
    rob_idx_t             brn_age;
    logic [ROB_DEPTH-1:0] younger;
    rob_entry_t           head_ent;

    assign head_ent = st_q.ent[st_q.head];

    rob_head_view i_head_view (
        .head_ent_i  (head_ent),
        .retire_ok_o (retire_ok),
        .fault_o     (fault_flush)
    );

    rob_age_kill i_age_kill (
        .head_i    (st_q.head),
        .brn_i     (cmpl_idx_i),
        .brn_age_o (brn_age),
        .younger_o (younger)
    );

    assign not_full   = (st_q.cnt != FULL_CNT);
    assign cmpl_hit   = cmpl_valid_i & st_q.ent[cmpl_idx_i].used & ~fault_flush;
    assign mispredict = cmpl_hit & cmpl_mispredict_i & st_q.ent[cmpl_idx_i].branch;
    assign disp_fire  = disp_valid_i & not_full & ~fault_flush & ~mispredict;

    always_comb begin
        st_d = st_q;
        if (fault_flush) begin
            for (int i = 0; i < ROB_DEPTH; i++) begin
                st_d.ent[i].used = 1'b0;
                st_d.ent[i].done = 1'b0;
            end
            st_d.head = '0;
            st_d.tail = '0;
            st_d.cnt  = '0;
        end else begin
            if (cmpl_hit) begin
                st_d.ent[cmpl_idx_i].done = 1'b1;
                st_d.ent[cmpl_idx_i].exc  = cmpl_exc_i;
            end
            if (retire_ok) begin
                st_d.ent[st_q.head].used = 1'b0;
                st_d.head = st_q.head + 1'b1;
            end
            if (mispredict) begin
                for (int i = 0; i < ROB_DEPTH; i++) begin
                    if (younger[i]) st_d.ent[i].used = 1'b0;
                end
                st_d.tail = cmpl_idx_i + 1'b1;
                st_d.cnt  = rob_cnt_t'(brn_age) + rob_cnt_t'(1) - rob_cnt_t'(retire_ok);
            end else begin
                st_d.cnt  = st_q.cnt + rob_cnt_t'(disp_fire) - rob_cnt_t'(retire_ok);
            end
            if (disp_fire) begin
                st_d.ent[st_q.tail].used   = 1'b1;
                st_d.ent[st_q.tail].done   = 1'b0;
                st_d.ent[st_q.tail].exc    = 1'b0;
                st_d.ent[st_q.tail].branch = disp_branch_i;
                st_d.ent[st_q.tail].areg   = disp_areg_i;
                st_d.ent[st_q.tail].pnew   = disp_pnew_i;
                st_d.ent[st_q.tail].pold   = disp_pold_i;
                st_d.tail = st_q.tail + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disp_ready_o      = not_full;
    assign disp_idx_o        = st_q.tail;
    assign cmt_valid_o       = retire_ok;
    assign cmt_areg_o        = head_ent.areg;
    assign cmt_pnew_o        = head_ent.pnew;
    assign cmt_free_preg_o   = head_ent.pold;
    assign kill_valid_o      = fault_flush | mispredict;
    assign kill_all_o        = fault_flush;
    assign kill_branch_idx_o = cmpl_idx_i;
    assign redirect_pc_o     = fault_flush ? HANDLER_PC : cmpl_target_i;

    AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready_o && !kill_valid_o) |=> $stable(disp_idx_o)); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT); // R2
    AST_ONE_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid_o && !kill_all_o) |=> (st_q.head == rob_idx_t'($past(st_q.head) + 1'b1))); // R4
    AST_ROLLBACK_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_valid_o && !kill_all_o) |=> (disp_idx_o == rob_idx_t'($past(kill_branch_idx_o) + 1'b1))); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        kill_all_o |=> (disp_idx_o == '0 && disp_ready_o && !cmt_valid_o && st_q.cnt == '0)); // R8
endmodule

// File: tb/test_rob_core.sv
module test_rob_core;
    localparam int DEPTH = 16;
    localparam logic [31:0] HPC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid_i = 0, disp_branch_i = 0;
    logic [4:0]  disp_areg_i = '0;
    logic [6:0]  disp_pnew_i = '0, disp_pold_i = '0;
    logic        disp_ready_o;
    logic [3:0]  disp_idx_o;
    logic        cmpl_valid_i = 0, cmpl_exc_i = 0, cmpl_mispredict_i = 0;
    logic [3:0]  cmpl_idx_i = '0;
    logic [31:0] cmpl_target_i = '0;
    logic        cmt_valid_o;
    logic [4:0]  cmt_areg_o;
    logic [6:0]  cmt_pnew_o, cmt_free_preg_o;
    logic        kill_valid_o, kill_all_o;
    logic [3:0]  kill_branch_idx_o;
    logic [31:0] redirect_pc_o;

    always #10 clk = ~clk;

    rob_core #(.PC_W(32), .HANDLER_PC(HPC)) i_rob_core (.*);

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";

    // behavioural model: ordered list of occupied slot numbers plus per-slot fields
    int ord[$];
    int m_tail = 0;
    bit m_done[DEPTH], m_exc[DEPTH], m_br[DEPTH];
    int m_areg[DEPTH], m_pn[DEPTH], m_po[DEPTH];
    int seq = 1;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    function automatic bit in_list(input int idx);
        foreach (ord[k]) if (ord[k] == idx) return 1'b1;
        return 1'b0;
    endfunction

    task automatic cyc(input bit dv, input bit dbr, input bit cv, input int cidx,
                       input bit cexc, input bit cmis, input logic [31:0] ctgt);
        bit e_flush, e_cmt, live, e_mis, e_ready;
        int h;
        disp_valid_i = dv; disp_branch_i = dbr;
        disp_areg_i = 5'(seq); disp_pnew_i = 7'(seq + 40); disp_pold_i = 7'(seq + 3);
        cmpl_valid_i = cv; cmpl_idx_i = 4'(cidx); cmpl_exc_i = cexc;
        cmpl_mispredict_i = cmis; cmpl_target_i = ctgt;
        #1;
        h = (ord.size() > 0) ? ord[0] : 0;
        e_flush = ord.size() > 0 && m_done[h] && m_exc[h];
        e_cmt   = ord.size() > 0 && m_done[h] && !m_exc[h];
        live    = cv && in_list(cidx) && !e_flush;
        e_mis   = live && cmis && m_br[cidx];
        e_ready = ord.size() < DEPTH;
        chk(disp_ready_o == e_ready, cur_req, "disp_ready (R2)", disp_ready_o, e_ready);
        chk(disp_idx_o == 4'(m_tail), cur_req, "disp_idx (R2)", disp_idx_o, m_tail);
        chk(cmt_valid_o == e_cmt, cur_req, "cmt_valid (R4)", cmt_valid_o, e_cmt);
        if (e_cmt) begin
            chk(cmt_areg_o == 5'(m_areg[h]), cur_req, "cmt_areg (R4)", cmt_areg_o, m_areg[h]);
            chk(cmt_pnew_o == 7'(m_pn[h]), cur_req, "cmt_pnew (R4)", cmt_pnew_o, m_pn[h]);
            chk(cmt_free_preg_o == 7'(m_po[h]), cur_req, "free preg (R4)", cmt_free_preg_o, m_po[h]);
        end
        chk(kill_valid_o == (e_flush || e_mis), cur_req, "kill_valid (R6)", kill_valid_o, e_flush || e_mis);
        chk(kill_all_o == e_flush, cur_req, "kill_all (R8)", kill_all_o, e_flush);
        if (e_flush)
            chk(redirect_pc_o == HPC, cur_req, "handler pc (R8)", redirect_pc_o, HPC);
        else if (e_mis) begin
            chk(redirect_pc_o == ctgt, cur_req, "redirect pc (R6)", redirect_pc_o, ctgt);
            chk(kill_branch_idx_o == 4'(cidx), cur_req, "kill idx (R6)", kill_branch_idx_o, cidx);
        end
        @(posedge clk);
        if (e_flush) begin
            ord.delete(); m_tail = 0;
        end else begin
            if (live) begin m_done[cidx] = 1'b1; m_exc[cidx] = cexc; end
            if (e_mis) begin
                while (ord[$] != cidx) void'(ord.pop_back());
                m_tail = (cidx + 1) % DEPTH;
            end
            if (e_cmt) void'(ord.pop_front());
            if (!e_mis && dv && e_ready) begin
                ord.push_back(m_tail);
                m_done[m_tail] = 0; m_exc[m_tail] = 0; m_br[m_tail] = dbr;
                m_areg[m_tail] = seq % 32; m_pn[m_tail] = (seq + 40) % 128; m_po[m_tail] = (seq + 3) % 128;
                m_tail = (m_tail + 1) % DEPTH;
            end
        end
        seq++;
        @(negedge clk);
    endtask

    task automatic disp(input bit br);                          cyc(1, br, 0, 0, 0, 0, 0); endtask
    task automatic comp(input int idx, input bit e, input bit m, input logic [31:0] t); cyc(0, 0, 1, idx, e, m, t); endtask
    task automatic idle();                                      cyc(0, 0, 0, 0, 0, 0, 0); endtask

    initial begin : watchdog
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        errors++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1"; idle();
        // R3 R4: out-of-order completion, in-order retirement
        cur_req = "R3";
        for (int i = 0; i < 4; i++) disp(0);
        comp(3, 0, 0, 0); comp(1, 0, 0, 0); comp(2, 0, 0, 0);
        cur_req = "R4"; comp(0, 0, 0, 0);
        repeat (5) idle();
        // R2: fill to full, dispatch while full is ignored, then drain
        cur_req = "R2";
        for (int i = 0; i < DEPTH + 2; i++) disp(0);
        for (int i = 0; i < DEPTH; i++) comp((4 + i) % DEPTH, 0, 0, 0);
        repeat (3) idle();
        // R11: two branches pending, younger resolves correctly first, older mispredicts
        cur_req = "R11";
        disp(0); disp(1); disp(0); disp(0); disp(1); disp(0);   // slots 4..9, branches 5 and 8
        comp(8, 0, 0, 0);
        cur_req = "R6"; comp(5, 0, 1, 32'hABCD_0040);
        // R5: completion to a killed slot
        cur_req = "R5"; comp(7, 0, 0, 0); comp(12, 0, 0, 0);
        disp(0); disp(0);
        comp(4, 0, 0, 0); idle(); comp(6, 0, 0, 0); comp(7, 0, 0, 0); idle(); idle();
        // R7: mispredict flag on a non-branch slot
        cur_req = "R7"; disp(0); disp(0); comp(9, 0, 1, 32'h1234); comp(8, 0, 0, 0);
        repeat (3) idle();
        // R9: dispatch in a mispredict cycle is dropped
        cur_req = "R9"; disp(1); disp(0);
        cyc(1, 0, 1, 10, 0, 1, 32'h0000_0800);
        comp(10, 0, 0, 0); repeat (2) idle();
        // R8: fault stored, taken only at the oldest slot
        cur_req = "R8"; disp(0); disp(0); disp(0);
        comp(12, 1, 0, 0); idle(); comp(11, 0, 0, 0); idle(); idle();
        // R10: fault at oldest slot beats a same-cycle mispredict; dispatch and completion dropped (R9)
        cur_req = "R10"; disp(0); disp(1); disp(0);
        comp(0, 1, 0, 0);
        cyc(1, 0, 1, 1, 0, 1, 32'h0000_0900);
        idle();
        // random mixture
        cur_req = "R3";
        for (int n = 0; n < 1500; n++) begin
            bit dv, br, cv, ex, mi;
            dv = ($urandom % 10) < 6; br = ($urandom % 4) == 0;
            cv = ($urandom % 10) < 6; ex = ($urandom % 25) == 0; mi = ($urandom % 5) == 0;
            cyc(dv, br, cv, $urandom % DEPTH, ex, mi, $urandom);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule